// File: doc/BRIEF.md
# Video RAM Write and Block-Copy Engine

This block sits between a CPU bus and a 32-bit-word video memory. Each bus request carries a window code, a word offset, a data word and a four-bit byte-enable mask. The window code selects one of several write behaviours. A transparent write leaves every zero data byte untouched, so zero acts as a colour key. A grouped fill writes four aligned words from a fill register. Two further windows set a source address and start a block copy from that source to a destination.

The block copy moves 256 words from the latched source to the destination given with the trigger. It moves one word every two clocks: a read, then a write. While the copy runs, the engine raises a busy flag and lowers its ready output, and it ignores any bus request. The latched source byte address is also exported for use as a display fetch base.

The memory is held inside the block as four single-port banks, interleaved by the low two bits of the word address. Each bank has per-byte write enables and a read latency of one cycle. A read window returns stored words so the contents can be observed.

Top module: `vram_blit_engine`

## Requirements
- R1: In window code 0 (transparent write), byte lane i (bits 8i+7..8i) of the addressed word is written only when busMask[i] is 1 and that data byte is nonzero. Every other lane keeps its old value.
- R2: In window code 1 (grouped fill), the two low bits of the offset are ignored. The selector is busWdata AND the byte-expanded busMask AND 0x0F0F0F0F. When the selector equals 0x0F0F0F0F, all four words of the aligned group receive the fill register value.
- R3: In window code 1, any selector other than 0x0F0F0F0F writes nothing. bulkReject is then high for exactly the one cycle after the request is accepted.
- R4: Window code 4 writes the bytes of busWdata selected by busMask into the fill register. The fill register resets to zero.
- R5: Window code 2 sets srcBase to (4 × busOffset) AND 0x7FFFF, visible from the cycle after acceptance. srcBase resets to zero.
- R6: Window code 3 copies 256 words. Word k goes from memory word srcBase/4 + k to word busOffset + k, for k = 0 to 255 in ascending order. Each word is read after the previous word has been written, so an overlapping copy propagates forward. Word addresses wrap modulo the memory size.
- R7: copyBusy rises in the cycle after a copy trigger is accepted and stays high for exactly 512 cycles. busReady is low while copyBusy is high, and a request made during that time has no effect.
- R8: Window code 5 reads the word at busOffset. rdValid is high, and rdData holds that word, in the cycle after acceptance only.
- R9: During and after reset, busReady is 1 and copyBusy, rdValid, bulkReject and srcBase are 0.
- R10: Window codes 6 and 7 change neither the memory nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Request valid; accepted when busReady is high |
| busWin | input | 3 | Window code selecting the operation |
| busOffset | input | 17 | Word offset of the request |
| busWdata | input | 32 | Write data |
| busMask | input | 4 | Byte-lane enables |
| busReady | output | 1 | Block can accept a request |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data word |
| copyBusy | output | 1 | Block copy in progress |
| srcBase | output | 19 | Latched source byte address |
| bulkReject | output | 1 | Pulse after a grouped fill with a partial selector |

## Verification
On every cycle, the assertions check four things. A transparent write never enables a lane whose data byte is zero. A grouped fill always drives all four banks with a full mask from the fill register. A rejected fill leaves the memory untouched. A copy stays busy for exactly twice its word count, and during that time only copy writes reach the memory. Other properties are visible only through the bench's scenarios, which follow the memory contents through a behavioural model. These are the forward propagation of an overlapping copy, address wrap, the loss of requests made while busy, and the byte merging of repeated transparent writes.

// File: rtl/vram_blit_pkg.sv
package vram_blit_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int BYTE_AW = 19;
  localparam int WORD_AW = BYTE_AW - 2;
  localparam int WIN_W   = 3;

  localparam logic [WIN_W-1:0] WIN_TRANSP = 3'd0;
  localparam logic [WIN_W-1:0] WIN_BULK   = 3'd1;
  localparam logic [WIN_W-1:0] WIN_SRC    = 3'd2;
  localparam logic [WIN_W-1:0] WIN_COPY   = 3'd3;
  localparam logic [WIN_W-1:0] WIN_FILL   = 3'd4;
  localparam logic [WIN_W-1:0] WIN_READ   = 3'd5;

  localparam logic [WORD_W-1:0] BULK_KEY = {LANES{8'h0F}};

  typedef enum logic [1:0] {DS_BUS, DS_FILL, DS_COPY} dsel_e;

  typedef struct packed {
    logic               memEn;
    logic               memWr;
    logic               allBanks;
    logic [WORD_AW-1:0] wordAddr;
    logic [LANES-1:0]   byteEn;
    dsel_e              dataSel;
    logic               loadFill;
    logic               readOut;
  } strobe_t;
endpackage

// File: rtl/vram_blit_ctrl.sv
module vram_blit_ctrl
  import vram_blit_pkg::*;
#(
  parameter int COPY_WORDS = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReq,
  input  logic [WIN_W-1:0]   busWin,
  input  logic [WORD_AW-1:0] busOffset,
  input  logic [WORD_W-1:0]  busWdata,
  input  logic [LANES-1:0]   busMask,
  output strobe_t            stb,
  output logic               busy,
  output logic [BYTE_AW-1:0] srcBase,
  output logic               bulkReject
);
  localparam int CNT_W     = $clog2(COPY_WORDS);
  localparam int BUSYLEN_W = $clog2(2 * COPY_WORDS) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} state_e;

  state_e             st;
  logic [CNT_W-1:0]   cnt;
  logic [WORD_AW-1:0] dstWord;
  logic               accept;
  logic [LANES-1:0]   nonZero;
  logic [WORD_W-1:0]  maskWide;
  logic               bulkOk;

  assign accept = busReq && (st == ST_IDLE);
  assign busy   = (st != ST_IDLE);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      nonZero[i]         = |busWdata[8*i +: 8];
      maskWide[8*i +: 8] = {8{busMask[i]}};
    end
    bulkOk = ((busWdata & maskWide & BULK_KEY) == BULK_KEY);
  end

  always_comb begin
    stb         = '0;
    stb.dataSel = DS_BUS;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          case (busWin)
            WIN_TRANSP: begin
              stb.memEn    = 1'b1;
              stb.memWr    = 1'b1;
              stb.wordAddr = busOffset;
              stb.byteEn   = busMask & nonZero;
            end
            WIN_BULK: begin
              if (bulkOk) begin
                stb.memEn    = 1'b1;
                stb.memWr    = 1'b1;
                stb.allBanks = 1'b1;
                stb.wordAddr = {busOffset[WORD_AW-1:2], 2'b00};
                stb.byteEn   = '1;
                stb.dataSel  = DS_FILL;
              end
            end
            WIN_FILL: begin
              stb.loadFill = 1'b1;
              stb.byteEn   = busMask;
            end
            WIN_READ: begin
              stb.memEn    = 1'b1;
              stb.wordAddr = busOffset;
              stb.readOut  = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_RD: begin
        stb.memEn    = 1'b1;
        stb.wordAddr = srcBase[BYTE_AW-1:2] + WORD_AW'(cnt);
      end
      ST_WR: begin
        stb.memEn    = 1'b1;
        stb.memWr    = 1'b1;
        stb.wordAddr = dstWord + WORD_AW'(cnt);
        stb.byteEn   = '1;
        stb.dataSel  = DS_COPY;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      dstWord    <= '0;
      srcBase    <= '0;
      bulkReject <= 1'b0;
    end else begin
      bulkReject <= accept && (busWin == WIN_BULK) && !bulkOk;
      unique case (st)
        ST_IDLE: begin
          if (accept && busWin == WIN_SRC) srcBase <= {busOffset, 2'b00};
          if (accept && busWin == WIN_COPY) begin
            dstWord <= busOffset;
            cnt     <= '0;
            st      <= ST_RD;
          end
        end
        ST_RD: st <= ST_WR;
        ST_WR: begin
          if (cnt == CNT_W'(COPY_WORDS - 1)) begin
            st <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= ST_RD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Run-length counter used only by the copy-span check
  logic [BUSYLEN_W-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else       busyLen <= busy ? busyLen + 1'b1 : '0;
  end

  p_copy_span_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == BUSYLEN_W'(2 * COPY_WORDS));

  p_reject_nowrite_r3: assert property (@(posedge clk) disable iff (!rstN)
    bulkReject |-> $past(!stb.memWr));
endmodule

// File: rtl/vram_blit_datapath.sv
module vram_blit_datapath
  import vram_blit_pkg::*;
#(
  parameter int RAM_WORDS_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] busWdata,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);
  localparam int BANK_AW    = RAM_WORDS_LOG2 - 2;
  localparam int BANK_DEPTH = 1 << BANK_AW;

  logic [LANES-1:0][WORD_W-1:0] bankOut;
  logic [LANES-1:0]             bankWe;
  logic [WORD_W-1:0]            fillReg;
  logic [WORD_W-1:0]            wdata;
  logic [1:0]                   laneQ;
  logic [BANK_AW-1:0]           bankAddr;
  logic [1:0]                   lane;
  logic                         unusedHighAddr;

  assign bankAddr       = stb.wordAddr[RAM_WORDS_LOG2-1:2];
  assign lane           = stb.wordAddr[1:0];
  assign unusedHighAddr = ^stb.wordAddr[WORD_AW-1:RAM_WORDS_LOG2];

  always_comb begin
    unique case (stb.dataSel)
      DS_FILL: wdata = fillReg;
      DS_COPY: wdata = bankOut[laneQ];
      default: wdata = busWdata;
    endcase
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [WORD_W-1:0] mem [BANK_DEPTH];
    logic [WORD_W-1:0] q;
    logic              hit;

    assign hit        = stb.memEn && (stb.allBanks || lane == 2'(b));
    assign bankWe[b]  = hit && stb.memWr;
    assign bankOut[b] = q;

    always_ff @(posedge clk) begin
      if (hit) begin
        if (stb.memWr) begin
          for (int i = 0; i < LANES; i++)
            if (stb.byteEn[i]) mem[bankAddr][8*i +: 8] <= wdata[8*i +: 8];
        end else begin
          q <= mem[bankAddr];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillReg <= '0;
      laneQ   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.readOut;
      if (stb.memEn && !stb.memWr) laneQ <= lane;
      if (stb.loadFill)
        for (int i = 0; i < LANES; i++)
          if (stb.byteEn[i]) fillReg[8*i +: 8] <= busWdata[8*i +: 8];
    end
  end

  assign rdData = bankOut[laneQ];

  logic [LANES-1:0] zeroLane;
  always_comb
    for (int i = 0; i < LANES; i++) zeroLane[i] = (busWdata[8*i +: 8] == 8'h00);

  p_key_lane_skip_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memWr && stb.dataSel == DS_BUS) |-> ((stb.byteEn & zeroLane) == '0));

  p_single_bank_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memWr && !stb.allBanks) |-> $onehot(bankWe));

  p_group_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.allBanks |-> (bankWe == '1 && stb.byteEn == '1 && stb.dataSel == DS_FILL));
endmodule

// File: rtl/vram_blit_engine.sv
module vram_blit_engine
  import vram_blit_pkg::*;
#(
  parameter int RAM_WORDS_LOG2 = 10,
  parameter int COPY_WORDS     = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busReq,
  input  logic [2:0]   busWin,
  input  logic [16:0]  busOffset,
  input  logic [31:0]  busWdata,
  input  logic [3:0]   busMask,
  output logic         busReady,
  output logic         rdValid,
  output logic [31:0]  rdData,
  output logic         copyBusy,
  output logic [18:0]  srcBase,
  output logic         bulkReject
);
  strobe_t stb;

  vram_blit_ctrl #(.COPY_WORDS(COPY_WORDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWin(busWin),
    .busOffset(busOffset), .busWdata(busWdata), .busMask(busMask),
    .stb(stb), .busy(copyBusy), .srcBase(srcBase), .bulkReject(bulkReject)
  );

  vram_blit_datapath #(.RAM_WORDS_LOG2(RAM_WORDS_LOG2)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .rdValid(rdValid), .rdData(rdData)
  );

  assign busReady = !copyBusy;

  p_busy_copy_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (copyBusy && stb.memWr) |-> stb.dataSel == DS_COPY);
endmodule

// File: tb/test_vram_blit_engine.sv
module test_vram_blit_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 1024;
  localparam int COPY_WORDS = 256;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic [2:0]  busWin = '0;
  logic [16:0] busOffset = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busMask = '0;
  logic        busReady, rdValid, copyBusy, bulkReject;
  logic [31:0] rdData;
  logic [18:0] srcBase;

  vram_blit_engine i_vram_blit_engine (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWin(busWin),
    .busOffset(busOffset), .busWdata(busWdata), .busMask(busMask),
    .busReady(busReady), .rdValid(rdValid), .rdData(rdData),
    .copyBusy(copyBusy), .srcBase(srcBase), .bulkReject(bulkReject)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit live = 0;

  logic [31:0] refMem [NWORDS];
  logic [31:0] refFill;
  logic [18:0] refSrc;
  int          busyCnt;
  bit          expRdValid, expReject;
  logic [31:0] expRd;
  string       expTag, tag;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      refFill = '0; refSrc = '0; busyCnt = 0; expRdValid = 0; expReject = 0;
    end else begin
      expRdValid = 0;
      expReject  = 0;
      if (busyCnt > 0) busyCnt--;
      else if (busReq) begin
        int off;
        off = int'(busOffset) % NWORDS;
        case (busWin)
          3'd0: for (int i = 0; i < 4; i++)
                  if (busMask[i] && busWdata[8*i +: 8] != 8'h00)
                    refMem[off][8*i +: 8] = busWdata[8*i +: 8];
          3'd1: begin
            logic [31:0] mw, sel;
            for (int i = 0; i < 4; i++) mw[8*i +: 8] = {8{busMask[i]}};
            sel = busWdata & mw & 32'h0F0F0F0F;
            if (sel == 32'h0F0F0F0F)
              for (int k = 0; k < 4; k++) refMem[(off & ~3) + k] = refFill;
            else expReject = 1;
          end
          3'd2: refSrc = 19'((int'(busOffset) * 4) & 32'h7FFFF);
          3'd3: begin
            int s;
            s = int'(refSrc) / 4;
            for (int k = 0; k < COPY_WORDS; k++)
              refMem[(off + k) % NWORDS] = refMem[(s + k) % NWORDS];
            busyCnt = 2 * COPY_WORDS;
          end
          3'd4: for (int i = 0; i < 4; i++)
                  if (busMask[i]) refFill[8*i +: 8] = busWdata[8*i +: 8];
          3'd5: begin expRdValid = 1; expRd = refMem[off]; expTag = tag; end
          default: ;
        endcase
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      check(busReady === (busyCnt == 0), "R7", "busReady", 32'(busReady), 32'(busyCnt == 0));
      check(copyBusy === (busyCnt != 0), "R7", "copyBusy", 32'(copyBusy), 32'(busyCnt != 0));
      check(srcBase === refSrc, "R5", "srcBase", 32'(srcBase), 32'(refSrc));
      check(bulkReject === expReject, "R3", "bulkReject", 32'(bulkReject), 32'(expReject));
      check(rdValid === expRdValid, "R8", "rdValid", 32'(rdValid), 32'(expRdValid));
      if (expRdValid) check(rdData === expRd, expTag, "rdData", rdData, expRd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic op(logic [2:0] w, int off, logic [31:0] d, logic [3:0] m);
    @(negedge clk);
    busWin = w; busOffset = 17'(off); busWdata = d; busMask = m; busReq = 1'b1;
    @(posedge clk);
    #1 busReq = 1'b0;
  endtask

  task automatic rd(int off, string t);
    tag = t;
    op(3'd5, off, 32'h0, 4'h0);
  endtask

  task automatic waitIdle();
    while (busyCnt != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    tag = "R8";
    repeat (3) @(negedge clk);
    check(busReady === 1'b1, "R9", "reset busReady", 32'(busReady), 32'h1);
    check(copyBusy === 1'b0, "R9", "reset copyBusy", 32'(copyBusy), 32'h0);
    check(rdValid === 1'b0, "R9", "reset rdValid", 32'(rdValid), 32'h0);
    check(bulkReject === 1'b0, "R9", "reset bulkReject", 32'(bulkReject), 32'h0);
    check(srcBase === 19'h0, "R9", "reset srcBase", 32'(srcBase), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    live = 1;

    // R2/R4: clear the whole memory with the zero fill register
    for (int i = 0; i < NWORDS / 4; i++) op(3'd1, i * 4, 32'h0F0F0F0F, 4'hF);
    rd(0, "R4"); rd(NWORDS - 1, "R2");

    // R4 masked fill load, R2 unaligned group fill
    op(3'd4, 0, 32'hA1B2C3D4, 4'b0101);
    op(3'd1, 17'h41, 32'hFFFFFFFF, 4'hF);
    for (int k = 16'h3F; k <= 16'h44; k++) rd(k, "R2");

    // R3 partial selectors
    op(3'd4, 0, 32'h11223344, 4'hF);
    op(3'd1, 17'h80, 32'hFFFFFFFF, 4'b0111);
    op(3'd1, 17'h84, 32'h0F0F0F0E, 4'hF);
    for (int k = 16'h80; k < 16'h88; k++) rd(k, "R3");

    // R1 transparent merges
    op(3'd0, 17'h10, 32'h00AB0000, 4'hF); rd(17'h10, "R1");
    op(3'd0, 17'h10, 32'h12000034, 4'hF); rd(17'h10, "R1");
    op(3'd0, 17'h10, 32'h55667788, 4'b1010); rd(17'h10, "R1");
    op(3'd0, 17'h10, 32'h00000000, 4'hF); rd(17'h10, "R1");

    // R10 unused window codes
    op(3'd6, 17'h10, 32'hFFFFFFFF, 4'hF);
    op(3'd7, 17'h10, 32'hFFFFFFFF, 4'hF);
    rd(17'h10, "R10"); rd(17'h11, "R10");

    // R5 source latch at the top of the offset range
    op(3'd2, 17'h1FFFF, 32'h0, 4'hF);

    // R6 copy with R7 ignored request while busy
    for (int i = 0; i < COPY_WORDS; i++)
      op(3'd0, 17'h100 + i, 32'(i) * 32'h01010101 + 32'h01020304, 4'hF);
    op(3'd2, 17'h100, 32'h0, 4'hF);
    op(3'd3, 17'h240, 32'h0, 4'hF);
    op(3'd0, 17'h250, 32'hFFFFFFFF, 4'hF);
    op(3'd5, 17'h250, 32'h0, 4'hF);
    waitIdle();
    rd(17'h240, "R6"); rd(17'h250, "R7"); rd(17'h2C7, "R6");
    rd(17'h33F, "R6"); rd(17'h340, "R6");

    // R6 overlapping forward copy
    op(3'd3, 17'h101, 32'h0, 4'hF);
    waitIdle();
    rd(17'h100, "R6"); rd(17'h101, "R6"); rd(17'h180, "R6"); rd(17'h200, "R6");

    // R6 copy wrapping past the end of memory
    op(3'd2, 17'h380, 32'h0, 4'hF);
    op(3'd3, 17'h3C0, 32'h0, 4'hF);
    waitIdle();
    rd(17'h3C0, "R6"); rd(17'h3FF, "R6"); rd(17'h000, "R6"); rd(17'h0BF, "R6");

    repeat (3) @(negedge clk);
    live = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule